// File: doc/BRIEF.md
# APB Root Interrupt Controller with Pulse Capture

This block is the root interrupt controller of a small system. It takes 64 interrupt sources and raises one interrupt request toward the CPU. A build-time mask picks the kind of each source. A level source is active while its input is high. A pulse source sets a sticky flag on a rising edge of its input, and the flag stays set until software clears it.

Software uses an APB slave port to reach all of the state: a global on bit, two enable words, two flag words, two read-only pending words and sixteen slot words. Each byte of a slot word names the source that owns one priority slot. The block also presents a vector: the source named by the lowest-numbered slot whose source is pending. The CPU side can use it without reading the pending words.

An interrupt service loop reads the pending words, handles each set bit, clears the flags it has served, and repeats until both pending words read zero.

Top module: `apb_irq_root`

## Requirements
- R1: After reset the on bit, both enable words and all flags are 0, slot s holds the value s, irq_req is 0 and vec_valid is 0.
- R2: Every APB transfer completes in its access phase (pready=1, pslverr=0). Reads of unused or misaligned addresses return 0, and writes to them change no state.
- R3: Register addresses: control 0x00, low flags 0x08, low enable 0x10, low pending 0x14, high flags 0x20, high enable 0x28, high pending 0x2C, slot words 0x40 to 0x7C. Bit i of a low word is source i, and bit i of a high word is source 32+i.
- R4: A source contributes to pending only while its enable bit is 1.
- R5: A level source's pending bit follows its input in the same cycle, and it falls as soon as the input falls.
- R6: A pulse source's flag is set by a 0-to-1 change of its input between two consecutive clock edges. The flag stays set after the input falls.
- R7: A flag-word write clears each flag whose data bit is 0 and leaves alone each flag whose data bit is 1, so it never sets a flag. A rising edge in the same cycle as a clearing write leaves that flag set.
- R8: Control bit 31 is the on bit, and the other control bits read 0. irq_req is 1 exactly when the on bit is 1 and at least one pending bit is 1.
- R9: Slot 4w+b is byte b (bits 8b+7..8b) of the slot word at 0x40+4w. Slot words store and read back all 8 bits of each byte.
- R10: vec_valid is 1 when some slot holds a value below 64 whose source is pending. In that case vec_idx is the value in the lowest such slot. Slots holding 64 or more are skipped.
- R11: With the default mask, sources 16-31 and 48-63 are pulse sources and the others are level sources. The flag bits of level sources always read 0.
- R12: A pulse flag is captured whatever the state of its enable bit. The source becomes pending once it is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1, no wait states |
| pslverr | output | 1 | Always 0 |
| src_in | input | N_SRC | Interrupt source inputs |
| irq_req | output | 1 | Interrupt request to the CPU |
| vec_valid | output | 1 | Some mapped source is pending |
| vec_idx | output | IDX_W | Source named by the winning slot |

## Verification
Two functions can act on the same flag in the same cycle: capturing a rising pulse edge and clearing the flag through a flag-word write. The bench causes this by raising a pulse input in the access phase of a write that clears that flag. The same write also clears a second flag, one with no new edge. The bench then reads the flag word back, and it expects the flag that saw the new edge still set and the other flag cleared. The hold assertion also covers cycles in which flags change with no write.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam int WORD_W      = 32;
   localparam int OFS_CTRL    = 'h00;
   localparam int OFS_SLOT0   = 'h40;
   localparam int CTRL_ON_BIT = 31;

   // enable word address per 32-source word
   function automatic int en_ofs(input int k);
      return (k == 0) ? 'h10 : 'h28;
   endfunction

   // flag word sits 8 bytes below its enable word
   function automatic int flag_ofs(input int k);
      return en_ofs(k) - 8;
   endfunction

   // pending word sits 4 bytes above its enable word
   function automatic int pend_ofs(input int k);
      return en_ofs(k) + 4;
   endfunction
endpackage

// File: rtl/intc_apb_regs.sv
module intc_apb_regs
   import intc_pkg::*;
#(
   parameter int N_SRC  = 64,
   parameter int ADDR_W = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    psel,
   input  logic                    penable,
   input  logic                    pwrite,
   input  logic [ADDR_W-1:0]       paddr,
   input  logic [WORD_W-1:0]       pwdata,
   input  logic [N_SRC-1:0]        flag_q,
   input  logic [N_SRC-1:0]        pend,
   output logic [WORD_W-1:0]       prdata,
   output logic                    ctrl_on,
   output logic [N_SRC-1:0]        en_q,
   output logic [N_SRC*8-1:0]      slot_q,
   output logic [N_SRC/WORD_W-1:0] flag_clr_we
);
   localparam int WORDS      = N_SRC / WORD_W;
   localparam int SLOT_WORDS = N_SRC / 4;
   localparam int SW_W       = $clog2(SLOT_WORDS);

   logic            wr;
   logic            slot_hit;
   logic [SW_W-1:0] slot_w;

   assign wr       = psel & penable & pwrite;
   assign slot_w   = paddr[2 +: SW_W];
   assign slot_hit = (paddr >= ADDR_W'(OFS_SLOT0)) &&
                     (paddr <  ADDR_W'(OFS_SLOT0 + 4*SLOT_WORDS)) &&
                     (paddr[1:0] == 2'b00);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_on <= 1'b0;
      else if (wr && (paddr == ADDR_W'(OFS_CTRL)))
         ctrl_on <= pwdata[CTRL_ON_BIT];
   end

   for (genvar k = 0; k < WORDS; k++) begin : g_word
      logic [WORD_W-1:0] en_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            en_r <= '0;
         else if (wr && (paddr == ADDR_W'(en_ofs(k))))
            en_r <= pwdata;
      end
      assign en_q[k*WORD_W +: WORD_W] = en_r;
      assign flag_clr_we[k] = wr && (paddr == ADDR_W'(flag_ofs(k)));
   end

   for (genvar w = 0; w < SLOT_WORDS; w++) begin : g_slot
      logic [WORD_W-1:0] slot_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_r <= {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)};
         else if (wr && slot_hit && (slot_w == SW_W'(w)))
            slot_r <= pwdata;
      end
      assign slot_q[w*WORD_W +: WORD_W] = slot_r;
   end

   always_comb begin
      prdata = '0;
      if (slot_hit)
         prdata = slot_q[int'(slot_w)*WORD_W +: WORD_W];
      if (paddr == ADDR_W'(OFS_CTRL))
         prdata[CTRL_ON_BIT] = ctrl_on;
      for (int k = 0; k < WORDS; k++) begin
         if (paddr == ADDR_W'(en_ofs(k)))   prdata = en_q[k*WORD_W +: WORD_W];
         if (paddr == ADDR_W'(flag_ofs(k))) prdata = flag_q[k*WORD_W +: WORD_W];
         if (paddr == ADDR_W'(pend_ofs(k))) prdata = pend[k*WORD_W +: WORD_W];
      end
   end
endmodule

// File: rtl/intc_src_latch.sv
module intc_src_latch
   import intc_pkg::*;
#(
   parameter int               N_SRC     = 64,
   parameter logic [N_SRC-1:0] PULSE_SRC = '0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_SRC-1:0]        src_in,
   input  logic [N_SRC-1:0]        en_q,
   input  logic [N_SRC/WORD_W-1:0] flag_clr_we,
   input  logic [WORD_W-1:0]       clr_data,
   output logic [N_SRC-1:0]        flag_q,
   output logic [N_SRC-1:0]        pend
);
   localparam int WORDS = N_SRC / WORD_W;

   logic [N_SRC-1:0] keep;
   logic             unused_keep;

   for (genvar k = 0; k < WORDS; k++) begin : g_keep
      assign keep[k*WORD_W +: WORD_W] = flag_clr_we[k] ? clr_data : '1;
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      if (PULSE_SRC[i]) begin : g_pulse
         logic src_q;
         logic flag_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               src_q  <= 1'b0;
               flag_r <= 1'b0;
            end else begin
               src_q  <= src_in[i];
               // a fresh edge wins over a clearing write
               flag_r <= (src_in[i] & ~src_q) | (flag_r & keep[i]);
            end
         end
         assign flag_q[i] = flag_r;
         assign pend[i]   = en_q[i] & flag_r;
      end else begin : g_level
         assign flag_q[i] = 1'b0;
         assign pend[i]   = en_q[i] & src_in[i];
      end
   end

   assign unused_keep = ^(keep & ~PULSE_SRC);
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
   parameter int N_SRC = 64,
   parameter int IDX_W = $clog2(N_SRC)
) (
   input  logic [N_SRC*8-1:0] slot_q,
   input  logic [N_SRC-1:0]   pend,
   output logic               vec_valid,
   output logic [IDX_W-1:0]   vec_idx
);
   always_comb begin
      vec_valid = 1'b0;
      vec_idx   = '0;
      // walk from the highest slot down so the lowest match remains
      for (int s = N_SRC - 1; s >= 0; s--) begin
         logic [7:0] sel;
         sel = slot_q[s*8 +: 8];
         if ((int'(sel) < N_SRC) && pend[sel[IDX_W-1:0]]) begin
            vec_valid = 1'b1;
            vec_idx   = sel[IDX_W-1:0];
         end
      end
   end
endmodule

// File: rtl/apb_irq_root.sv
module apb_irq_root
   import intc_pkg::*;
#(
   parameter int               N_SRC     = 64,
   parameter int               ADDR_W    = 12,
   parameter logic [N_SRC-1:0] PULSE_SRC = 64'hFFFF_0000_FFFF_0000,
   localparam int              IDX_W     = $clog2(N_SRC),
   localparam int              WORDS     = N_SRC / WORD_W
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [WORD_W-1:0] pwdata,
   output logic [WORD_W-1:0] prdata,
   output logic              pready,
   output logic              pslverr,
   input  logic [N_SRC-1:0]  src_in,
   output logic              irq_req,
   output logic              vec_valid,
   output logic [IDX_W-1:0]  vec_idx
);
   initial begin
      assert (N_SRC == 2 * WORD_W) else $error("N_SRC must fill the two source words");
      assert (ADDR_W >= 7)         else $error("ADDR_W too small for the slot region");
   end

   logic             ctrl_on;
   logic [N_SRC-1:0] en_q;
   logic [N_SRC-1:0] flag_q;
   logic [N_SRC-1:0] pend;
   logic [N_SRC*8-1:0] slot_q;
   logic [WORDS-1:0] flag_clr_we;

   intc_apb_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_regs (
      .clk(pclk), .rst_n(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
      .flag_q(flag_q), .pend(pend), .prdata(prdata), .ctrl_on(ctrl_on),
      .en_q(en_q), .slot_q(slot_q), .flag_clr_we(flag_clr_we)
   );

   intc_src_latch #(.N_SRC(N_SRC), .PULSE_SRC(PULSE_SRC)) u_latch (
      .clk(pclk), .rst_n(presetn), .src_in(src_in), .en_q(en_q),
      .flag_clr_we(flag_clr_we), .clr_data(pwdata),
      .flag_q(flag_q), .pend(pend)
   );

   intc_prio_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
      .slot_q(slot_q), .pend(pend), .vec_valid(vec_valid), .vec_idx(vec_idx)
   );

   assign irq_req = ctrl_on & (|pend);
   assign pready  = 1'b1;
   assign pslverr = 1'b0;
endmodule

// File: rtl/apb_irq_root_chk.sv
module apb_irq_root_chk #(
   parameter int N_SRC = 64,
   parameter int IDX_W = $clog2(N_SRC)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctrl_on,
   input logic             irq_req,
   input logic             vec_valid,
   input logic [IDX_W-1:0] vec_idx,
   input logic [N_SRC-1:0] pend,
   input logic [N_SRC-1:0] flag_q,
   input logic [1:0]       flag_clr_we
);
   // R8: no request while the controller is off
   a_r8_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_on |-> !irq_req);

   // R8: a request always has a pending source behind it
   a_r8_req_has_pend: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (pend != '0));

   // R10: the vector names a pending source
   a_r10_vec_pending: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> pend[vec_idx]);

   // R10: nothing pending means no vector
   a_r10_idle_novec: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == '0) |-> !vec_valid);

   // R7: flags only fall through a flag-word write
   a_r7_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(flag_clr_we[0]) |->
         ((flag_q[31:0] & $past(flag_q[31:0])) == $past(flag_q[31:0])));

   a_r7_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(flag_clr_we[1]) |->
         ((flag_q[63:32] & $past(flag_q[63:32])) == $past(flag_q[63:32])));
endmodule

bind apb_irq_root apb_irq_root_chk #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_chk (
   .clk(pclk), .rst_n(presetn), .ctrl_on(ctrl_on), .irq_req(irq_req),
   .vec_valid(vec_valid), .vec_idx(vec_idx), .pend(pend),
   .flag_q(flag_q), .flag_clr_we(flag_clr_we)
);

// File: tb/tb_apb_irq_root.sv
module tb_apb_irq_root;
   localparam logic [11:0] A_CTRL = 12'h000, A_FLO = 12'h008, A_ELO = 12'h010,
                           A_PLO  = 12'h014, A_FHI = 12'h020, A_EHI = 12'h028,
                           A_PHI  = 12'h02C, A_SL0 = 12'h040, A_SL15 = 12'h07C;

   logic        pclk = 1'b0;
   logic        presetn = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        pready, pslverr;
   logic [63:0] src_in = '0;
   logic        irq_req, vec_valid;
   logic [5:0]  vec_idx;

   int checks = 0;
   int errors = 0;

   always #5 pclk = ~pclk;

   apb_irq_root dut (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pready(pready), .pslverr(pslverr), .src_in(src_in),
      .irq_req(irq_req), .vec_valid(vec_valid), .vec_idx(vec_idx)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic apb_wr(input logic [11:0] a, input logic [31:0] d,
                         input logic [63:0] pulse = '0);
      @(negedge pclk);
      psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
      @(negedge pclk);
      penable = 1'b1;
      src_in  = src_in | pulse;
      #1;
      chk("R2 wr ready/err", {30'd0, pready, pslverr}, 32'd2);
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
      src_in = src_in & ~pulse;
   endtask

   task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge pclk);
      psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
      @(negedge pclk);
      penable = 1'b1;
      #1;
      d = prdata;
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] d;
      apb_rd(a, d);
      chk(req, d, exp);
   endtask

   task automatic pulse(input logic [63:0] m);
      @(negedge pclk); src_in = src_in | m;
      @(negedge pclk); src_in = src_in & ~m;
   endtask

   task automatic t_reset;
      #1;
      chk("R1 irq_req", {31'd0, irq_req}, 32'd0);
      chk("R1 vec_valid", {31'd0, vec_valid}, 32'd0);
      rd_chk("R1 ctrl", A_CTRL, 32'd0);
      rd_chk("R1 en lo", A_ELO, 32'd0);
      rd_chk("R1 en hi", A_EHI, 32'd0);
      rd_chk("R1 flag hi", A_FHI, 32'd0);
      rd_chk("R1 slot0", A_SL0, 32'h03020100);
      rd_chk("R1 slot15", A_SL15, 32'h3F3E3D3C);
   endtask

   task automatic t_apb;
      apb_wr(12'h004, 32'hFFFF_FFFF);
      rd_chk("R2 unused read", 12'h004, 32'd0);
      apb_wr(12'h011, 32'hFFFF_FFFF);
      rd_chk("R2 misaligned write ignored", A_ELO, 32'd0);
      rd_chk("R2 beyond slots", 12'h080, 32'd0);
      apb_wr(A_CTRL, 32'hFFFF_FFFF);
      rd_chk("R8 ctrl only bit31", A_CTRL, 32'h8000_0000);
   endtask

   task automatic t_level;
      @(negedge pclk); src_in[3] = 1'b1;
      rd_chk("R4 disabled not pending", A_PLO, 32'd0);
      #1 chk("R4 no irq", {31'd0, irq_req}, 32'd0);
      apb_wr(A_ELO, 32'h0000_0008);
      rd_chk("R3 R5 pend lo", A_PLO, 32'h0000_0008);
      #1;
      chk("R8 irq on", {31'd0, irq_req}, 32'd1);
      chk("R10 vec", {25'd0, vec_valid, vec_idx}, {25'd0, 1'b1, 6'd3});
      apb_wr(A_CTRL, 32'h0);
      #1 chk("R8 off gates irq", {31'd0, irq_req}, 32'd0);
      apb_wr(A_CTRL, 32'h8000_0000);
      @(negedge pclk); src_in[3] = 1'b0; #1;
      chk("R5 level falls", {31'd0, irq_req}, 32'd0);
      rd_chk("R5 pend cleared", A_PLO, 32'd0);
      apb_wr(A_ELO, 32'h0);
   endtask

   task automatic t_pulse;
      pulse(64'd1 << 20);
      rd_chk("R6 R12 flag captured while disabled", A_FLO, 32'h0010_0000);
      rd_chk("R4 flag not pending while disabled", A_PLO, 32'd0);
      apb_wr(A_ELO, 32'h0010_0000);
      rd_chk("R12 pending once enabled", A_PLO, 32'h0010_0000);
      #1 chk("R10 vec pulse", {25'd0, vec_valid, vec_idx}, {25'd0, 1'b1, 6'd20});
      apb_wr(A_FLO, ~32'h0010_0000);
      rd_chk("R7 flag cleared", A_FLO, 32'd0);
      rd_chk("R7 pend dropped", A_PLO, 32'd0);
      apb_wr(A_FLO, 32'hFFFF_FFFF);
      rd_chk("R7 write 1 never sets", A_FLO, 32'd0);
      pulse(64'd1 << 5);
      rd_chk("R11 level source has no flag", A_FLO, 32'd0);
      apb_wr(A_ELO, 32'h0);
   endtask

   task automatic t_collide;
      pulse((64'd1 << 49) | (64'd1 << 50));
      rd_chk("R6 two flags hi", A_FHI, 32'h0006_0000);
      apb_wr(A_FHI, 32'h0, 64'd1 << 50);
      rd_chk("R7 edge beats clear", A_FHI, 32'h0004_0000);
      apb_wr(A_FHI, 32'h0);
      rd_chk("R7 cleared after", A_FHI, 32'd0);
   endtask

   task automatic t_prio;
      @(negedge pclk); src_in[2] = 1'b1; src_in[7] = 1'b1;
      apb_wr(A_ELO, 32'h0000_0084);
      #1 chk("R10 lowest slot", {25'd0, vec_valid, vec_idx}, {25'd0, 1'b1, 6'd2});
      apb_wr(A_SL0, 32'h0302_0107);
      #1 chk("R9 R10 remapped slot0", {25'd0, vec_valid, vec_idx}, {25'd0, 1'b1, 6'd7});
      apb_wr(A_SL0, 32'h0302_01C7);
      #1 chk("R10 out-of-range skipped", {25'd0, vec_valid, vec_idx}, {25'd0, 1'b1, 6'd2});
      rd_chk("R9 full byte readback", A_SL0, 32'h0302_01C7);
      apb_wr(A_SL0, 32'h0302_0100);
      apb_wr(A_ELO, 32'h0);
      @(negedge pclk); src_in[2] = 1'b0; src_in[7] = 1'b0;
      apb_wr(A_EHI, 32'h1000_0000);
      pulse(64'd1 << 60);
      #1;
      chk("R10 high word vec", {25'd0, vec_valid, vec_idx}, {25'd0, 1'b1, 6'd60});
      chk("R8 irq from high", {31'd0, irq_req}, 32'd1);
      rd_chk("R3 pend hi", A_PHI, 32'h1000_0000);
      apb_wr(A_FHI, 32'h0);
      #1 chk("R10 vec clears", {31'd0, vec_valid}, 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge pclk);
      errors++;
      $display("FAIL watchdog act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge pclk);
      presetn = 1'b1;
      t_reset();
      t_apb();
      t_level();
      t_pulse();
      t_collide();
      t_prio();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule